// File: doc/BRIEF.md
# Phase-Tagged eDRAM Line Refresh Controller

This block decides, for each line of an eDRAM cache, whether a refresh is due and whether the line should instead be retired. The retention period is split into four equal phases. A phase timer outside the block marks each phase boundary with a single-cycle tick. For every line the controller keeps a valid bit, a dirty bit, the phase of the line's last touch and a countdown of refreshes still allowed. A line is therefore refreshed once per retention period, measured from its own last access or refresh, and not on a global sweep.

After every tick the controller walks all lines, one per cycle. A line gets a refresh request only if it is valid and its recorded phase equals the new phase. The refresh request is held under a valid/ready handshake. If a due line's countdown is already zero, the line is retired instead of refreshed. A dirty line produces a writeback pulse and a clean line produces an invalidate pulse, and the line becomes invalid.

The access port reports every cache access as a line index plus a read/write flag. An access re-stamps the line's phase and reloads its countdown. The data array, the writeback datapath and the tag lookup live outside this block.

Top module: `edram_refresh_ctrl`

## Requirements
- R1: After reset all lines are invalid, `cur_phase_o` is 0, `scan_busy_o` is 0, and no refresh, writeback, invalidate or overrun output is active.
- R2: Each `phase_tick_i` advances `cur_phase_o` by one, wrapping from 3 to 0. It also raises `scan_busy_o` for exactly `NUM_LINES` cycles when the scan is not stalled.
- R3: During a scan, a refresh request with `rfr_idx_o` = k is issued only for a valid line k whose recorded phase equals `cur_phase_o`. Requests come out in increasing line index.
- R4: An access stamps the line with the `cur_phase_o` value of that cycle and makes the line valid. A write also marks the line dirty.
- R5: An access reloads the countdown with `DIRTY_BUDGET` when the access is a write or the line is already dirty, and with `CLEAN_BUDGET` otherwise. Each refresh decrements the countdown. A due line whose countdown is zero is not refreshed. Instead it raises `wb_req_o` if dirty or `inv_req_o` if clean, for one cycle, with `evict_idx_o` = line index. The two pulses are never active together.
- R6: A retired line is invalid and receives no further refresh or retire request until it is accessed again.
- R7: While `rfr_valid_o` is high and `rfr_ready_i` is low, `rfr_valid_o` stays high, `rfr_idx_o` stays unchanged and the scan pauses.
- R8: A tick that arrives while a scan is still running pulses `overrun_o` high for one cycle. The scan then restarts from line 0 under the new phase.
- R9: When an access targets the line the scan examines in that same cycle, that line gets no refresh or retire request and the access update is applied.
- R10: A read access to a dirty line keeps it dirty and reloads `DIRTY_BUDGET`, so the line later ends with a writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_tick_i | input | 1 | Single-cycle phase boundary marker |
| acc_valid_i | input | 1 | Cache access this cycle |
| acc_idx_i | input | IDX_W | Line index of the access |
| acc_write_i | input | 1 | Access is a write |
| rfr_valid_o | output | 1 | Refresh request pending |
| rfr_ready_i | input | 1 | Refresh request accepted |
| rfr_idx_o | output | IDX_W | Line to refresh |
| wb_req_o | output | 1 | Writeback-and-drop pulse for a dirty line |
| inv_req_o | output | 1 | Invalidate pulse for a clean line |
| evict_idx_o | output | IDX_W | Line named by the writeback or invalidate pulse |
| cur_phase_o | output | 2 | Current phase |
| scan_busy_o | output | 1 | Scan in progress |
| overrun_o | output | 1 | Tick arrived during a running scan |

## Verification
The main function is driven by a scripted sequence of accesses and ticks. The sequence mixes clean reads, writes, and reads of lines already dirty. It collects, for each scan, the sets of refreshed, written-back and invalidated lines. Lines stamped in different phases show that only the matching phase is served. Dirty and clean lines with unequal budgets separate the writeback path from the invalidate path and show the right refresh count before each. A read of a dirty line shows the budget reload without loss of dirtiness.

Directed cases cover the rest. A held-off ready shows the request and the scan both freezing. A tick placed mid-scan must raise the overrun pulse. An access aimed at exactly the cycle the scan reaches that line must suppress its request.

// File: rtl/edram_rfr_pkg.sv
package edram_rfr_pkg;
  localparam int PHASE_W    = 2;
  localparam int NUM_PHASES = 1 << PHASE_W;

  typedef enum logic [0:0] {
    SCAN_IDLE,
    SCAN_RUN
  } scan_state_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_REFRESH,
    ACT_RETIRE
  } scan_act_e;
endpackage

// File: rtl/rfr_scan_seq.sv
module rfr_scan_seq
  import edram_rfr_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               stall_i,
  output logic [PHASE_W-1:0] cur_phase_o,
  output logic [IDX_W-1:0]   ptr_o,
  output logic               examine_o,
  output logic               busy_o,
  output logic               overrun_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

  scan_state_e        state_q;
  logic [IDX_W-1:0]   ptr_q;
  logic [PHASE_W-1:0] phase_q;
  logic               overrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SCAN_IDLE;
      ptr_q     <= '0;
      phase_q   <= '0;
      overrun_q <= 1'b0;
    end else if (tick_i) begin
      // a tick always restarts the walk under the new phase
      phase_q   <= phase_q + 1'b1;
      state_q   <= SCAN_RUN;
      ptr_q     <= '0;
      overrun_q <= (state_q == SCAN_RUN);
    end else begin
      overrun_q <= 1'b0;
      if (state_q == SCAN_RUN && !stall_i) begin
        if (ptr_q == LAST) state_q <= SCAN_IDLE;
        else               ptr_q   <= ptr_q + 1'b1;
      end
    end
  end

  assign cur_phase_o = phase_q;
  assign ptr_o       = ptr_q;
  assign busy_o      = (state_q == SCAN_RUN);
  assign examine_o   = (state_q == SCAN_RUN) && !stall_i && !tick_i;
  assign overrun_o   = overrun_q;
endmodule

// File: rtl/rfr_line_table.sv
module rfr_line_table
  import edram_rfr_pkg::*;
#(
  parameter int NUM_LINES    = 16,
  parameter int CNT_W        = 2,
  parameter int DIRTY_BUDGET = 3,
  parameter int CLEAN_BUDGET = 2,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [IDX_W-1:0]   acc_idx_i,
  input  logic               acc_write_i,
  input  logic [PHASE_W-1:0] cur_phase_i,
  input  scan_act_e          act_i,
  input  logic [IDX_W-1:0]   act_idx_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic               rd_dirty_o,
  output logic [PHASE_W-1:0] rd_phase_o,
  output logic [CNT_W-1:0]   rd_cnt_o
);
  localparam logic [CNT_W-1:0] LOAD_DIRTY = CNT_W'(DIRTY_BUDGET);
  localparam logic [CNT_W-1:0] LOAD_CLEAN = CNT_W'(CLEAN_BUDGET);

  logic [NUM_LINES-1:0] valid_w;
  logic [NUM_LINES-1:0] dirty_w;
  logic [PHASE_W-1:0]   phase_w [NUM_LINES];
  logic [CNT_W-1:0]     cnt_w   [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic               valid_q, dirty_q;
    logic [PHASE_W-1:0] phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               acc_hit, act_hit, keep_dirty;

    assign acc_hit    = acc_valid_i && (acc_idx_i == IDX_W'(i));
    assign act_hit    = (act_idx_i == IDX_W'(i));
    assign keep_dirty = valid_q && dirty_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
        phase_q <= '0;
        cnt_q   <= '0;
      end else if (acc_hit) begin
        valid_q <= 1'b1;
        dirty_q <= keep_dirty || acc_write_i;
        phase_q <= cur_phase_i;
        cnt_q   <= (keep_dirty || acc_write_i) ? LOAD_DIRTY : LOAD_CLEAN;
      end else if (act_hit && act_i == ACT_REFRESH) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (act_hit && act_i == ACT_RETIRE) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
      end
    end

    assign valid_w[i] = valid_q;
    assign dirty_w[i] = dirty_q;
    assign phase_w[i] = phase_q;
    assign cnt_w[i]   = cnt_q;
  end

  assign rd_valid_o = valid_w[rd_idx_i];
  assign rd_dirty_o = dirty_w[rd_idx_i];
  assign rd_phase_o = phase_w[rd_idx_i];
  assign rd_cnt_o   = cnt_w[rd_idx_i];
endmodule

// File: rtl/rfr_decide.sv
module rfr_decide
  import edram_rfr_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int CNT_W     = 2,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               examine_i,
  input  logic [IDX_W-1:0]   ptr_i,
  input  logic [PHASE_W-1:0] cur_phase_i,
  input  logic               line_valid_i,
  input  logic               line_dirty_i,
  input  logic [PHASE_W-1:0] line_phase_i,
  input  logic [CNT_W-1:0]   line_cnt_i,
  input  logic               acc_valid_i,
  input  logic [IDX_W-1:0]   acc_idx_i,
  input  logic               rfr_ready_i,
  output scan_act_e          act_o,
  output logic               stall_o,
  output logic               rfr_valid_o,
  output logic [IDX_W-1:0]   rfr_idx_o,
  output logic               wb_req_o,
  output logic               inv_req_o,
  output logic [IDX_W-1:0]   evict_idx_o
);
  logic             rfr_valid_q, wb_q, inv_q;
  logic [IDX_W-1:0] rfr_idx_q, evict_idx_q;
  logic             collide, due;

  // access to the examined line takes precedence over the scan
  assign collide = acc_valid_i && (acc_idx_i == ptr_i);
  assign due     = examine_i && line_valid_i && (line_phase_i == cur_phase_i) && !collide;

  always_comb begin
    act_o = ACT_NONE;
    if (due) act_o = (line_cnt_i == '0) ? ACT_RETIRE : ACT_REFRESH;
  end

  assign stall_o = rfr_valid_q && !rfr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rfr_valid_q <= 1'b0;
      rfr_idx_q   <= '0;
      wb_q        <= 1'b0;
      inv_q       <= 1'b0;
      evict_idx_q <= '0;
    end else begin
      if (act_o == ACT_REFRESH) begin
        rfr_valid_q <= 1'b1;
        rfr_idx_q   <= ptr_i;
      end else if (rfr_ready_i) begin
        rfr_valid_q <= 1'b0;
      end
      wb_q  <= (act_o == ACT_RETIRE) && line_dirty_i;
      inv_q <= (act_o == ACT_RETIRE) && !line_dirty_i;
      if (act_o == ACT_RETIRE) evict_idx_q <= ptr_i;
    end
  end

  assign rfr_valid_o = rfr_valid_q;
  assign rfr_idx_o   = rfr_idx_q;
  assign wb_req_o    = wb_q;
  assign inv_req_o   = inv_q;
  assign evict_idx_o = evict_idx_q;
endmodule

// File: rtl/edram_refresh_ctrl.sv
module edram_refresh_ctrl
  import edram_rfr_pkg::*;
#(
  parameter int NUM_LINES    = 16,
  parameter int DIRTY_BUDGET = 3,
  parameter int CLEAN_BUDGET = 2,
  localparam int IDX_W   = $clog2(NUM_LINES),
  localparam int MAX_BUD = (DIRTY_BUDGET > CLEAN_BUDGET) ? DIRTY_BUDGET : CLEAN_BUDGET,
  localparam int CNT_W   = $clog2(MAX_BUD + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_tick_i,
  input  logic               acc_valid_i,
  input  logic [IDX_W-1:0]   acc_idx_i,
  input  logic               acc_write_i,
  output logic               rfr_valid_o,
  input  logic               rfr_ready_i,
  output logic [IDX_W-1:0]   rfr_idx_o,
  output logic               wb_req_o,
  output logic               inv_req_o,
  output logic [IDX_W-1:0]   evict_idx_o,
  output logic [PHASE_W-1:0] cur_phase_o,
  output logic               scan_busy_o,
  output logic               overrun_o
);
  logic [IDX_W-1:0]   ptr;
  logic               examine, stall;
  logic               line_valid, line_dirty;
  logic [PHASE_W-1:0] line_phase;
  logic [CNT_W-1:0]   line_cnt;
  scan_act_e          act;

  rfr_scan_seq #(.NUM_LINES(NUM_LINES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (phase_tick_i),
    .stall_i     (stall),
    .cur_phase_o (cur_phase_o),
    .ptr_o       (ptr),
    .examine_o   (examine),
    .busy_o      (scan_busy_o),
    .overrun_o   (overrun_o)
  );

  rfr_line_table #(
    .NUM_LINES    (NUM_LINES),
    .CNT_W        (CNT_W),
    .DIRTY_BUDGET (DIRTY_BUDGET),
    .CLEAN_BUDGET (CLEAN_BUDGET)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_idx_i   (acc_idx_i),
    .acc_write_i (acc_write_i),
    .cur_phase_i (cur_phase_o),
    .act_i       (act),
    .act_idx_i   (ptr),
    .rd_idx_i    (ptr),
    .rd_valid_o  (line_valid),
    .rd_dirty_o  (line_dirty),
    .rd_phase_o  (line_phase),
    .rd_cnt_o    (line_cnt)
  );

  rfr_decide #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_decide (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .examine_i    (examine),
    .ptr_i        (ptr),
    .cur_phase_i  (cur_phase_o),
    .line_valid_i (line_valid),
    .line_dirty_i (line_dirty),
    .line_phase_i (line_phase),
    .line_cnt_i   (line_cnt),
    .acc_valid_i  (acc_valid_i),
    .acc_idx_i    (acc_idx_i),
    .rfr_ready_i  (rfr_ready_i),
    .act_o        (act),
    .stall_o      (stall),
    .rfr_valid_o  (rfr_valid_o),
    .rfr_idx_o    (rfr_idx_o),
    .wb_req_o     (wb_req_o),
    .inv_req_o    (inv_req_o),
    .evict_idx_o  (evict_idx_o)
  );
endmodule

// File: rtl/edram_refresh_ctrl_chk.sv
module edram_refresh_ctrl_chk
  import edram_rfr_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               phase_tick_i,
  input logic               rfr_ready_i,
  input logic               rfr_valid_o,
  input logic [IDX_W-1:0]   rfr_idx_o,
  input logic               wb_req_o,
  input logic               inv_req_o,
  input logic [PHASE_W-1:0] cur_phase_o,
  input logic               scan_busy_o,
  input logic               overrun_o
);
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_tick_i |=> cur_phase_o == PHASE_W'($past(cur_phase_o) + 1'b1)); // R2

  AST_RFR_FROM_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rfr_valid_o) |-> $past(scan_busy_o)); // R3

  AST_RETIRE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_req_o && inv_req_o)); // R5

  AST_RETIRE_FROM_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o || inv_req_o) |-> $past(scan_busy_o)); // R5

  AST_RFR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfr_valid_o && !rfr_ready_i) |=> (rfr_valid_o && $stable(rfr_idx_o))); // R7

  AST_OVERRUN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> ($past(phase_tick_i) && $past(scan_busy_o))); // R8
endmodule

bind edram_refresh_ctrl edram_refresh_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .phase_tick_i (phase_tick_i),
  .rfr_ready_i  (rfr_ready_i),
  .rfr_valid_o  (rfr_valid_o),
  .rfr_idx_o    (rfr_idx_o),
  .wb_req_o     (wb_req_o),
  .inv_req_o    (inv_req_o),
  .cur_phase_o  (cur_phase_o),
  .scan_busy_o  (scan_busy_o),
  .overrun_o    (overrun_o)
);

// File: tb/edram_refresh_ctrl_bench.sv
module edram_refresh_ctrl_bench;
  localparam int LINES = 8;
  localparam int NV    = 22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_tick = 1'b0;
  logic       acc_valid = 1'b0;
  logic [2:0] acc_idx = '0;
  logic       acc_write = 1'b0;
  logic       rfr_ready = 1'b1;
  logic       rfr_valid, wb_req, inv_req, scan_busy, overrun;
  logic [2:0] rfr_idx, evict_idx;
  logic [1:0] cur_phase;

  int         n_chk = 0;
  int         n_fail = 0;
  logic [1:0] exp_phase = '0;

  always #2.5ns clk = ~clk;

  edram_refresh_ctrl #(.NUM_LINES(LINES), .DIRTY_BUDGET(2), .CLEAN_BUDGET(1)) u_edram_refresh_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .phase_tick_i(phase_tick),
    .acc_valid_i(acc_valid), .acc_idx_i(acc_idx), .acc_write_i(acc_write),
    .rfr_valid_o(rfr_valid), .rfr_ready_i(rfr_ready), .rfr_idx_o(rfr_idx),
    .wb_req_o(wb_req), .inv_req_o(inv_req), .evict_idx_o(evict_idx),
    .cur_phase_o(cur_phase), .scan_busy_o(scan_busy), .overrun_o(overrun)
  );

  // {tick, idx[2:0], write, refresh mask, writeback mask, invalidate mask}
  // dirty budget 2, clean budget 1
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // R4 clean read, phase 0
    {1'b0, 3'd1, 1'b1, 8'h00, 8'h00, 8'h00},  // R4 write, phase 0
    {1'b0, 3'd3, 1'b1, 8'h00, 8'h00, 8'h00},  // R4 write, phase 0
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> phase 1, no match
    {1'b0, 3'd4, 1'b0, 8'h00, 8'h00, 8'h00},  // R4 clean read, phase 1
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> 2
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> 3
    {1'b1, 3'd0, 1'b0, 8'h0B, 8'h00, 8'h00},  // -> 0, R3 lines 0,1,3
    {1'b1, 3'd0, 1'b0, 8'h10, 8'h00, 8'h00},  // -> 1, line 4
    {1'b0, 3'd3, 1'b0, 8'h00, 8'h00, 8'h00},  // R10 read of dirty line, phase 1
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> 2
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> 3
    {1'b1, 3'd0, 1'b0, 8'h02, 8'h00, 8'h01},  // -> 0, R5 line 0 invalidated
    {1'b1, 3'd0, 1'b0, 8'h08, 8'h00, 8'h10},  // -> 1, line 4 invalidated
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> 2
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> 3
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h02, 8'h00},  // -> 0, R5 wb line 1, R6 line 0 silent
    {1'b1, 3'd0, 1'b0, 8'h08, 8'h00, 8'h00},  // -> 1
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> 2
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> 3
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00},  // -> 0, R6 lines 0,1 silent
    {1'b1, 3'd0, 1'b0, 8'h00, 8'h08, 8'h00}   // -> 1, R10 line 3 ends in writeback
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_access(input logic [2:0] idx, input logic wr);
    acc_valid = 1'b1; acc_idx = idx; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  // tick then collect one scan; col >= 0 drives a read of line col as the scan reaches it
  task automatic run_scan(input logic [7:0] er, input logic [7:0] ew, input logic [7:0] ei, input int col);
    logic [7:0] gr = '0;
    logic [7:0] gw = '0;
    logic [7:0] gi = '0;
    phase_tick = 1'b1;
    @(negedge clk);
    phase_tick = 1'b0;
    exp_phase = exp_phase + 2'd1;
    chk(cur_phase == exp_phase, "R2", "phase", int'(cur_phase), int'(exp_phase));
    chk(scan_busy == 1'b1, "R2", "busy after tick", int'(scan_busy), 1);
    for (int j = 0; j < LINES + 3; j++) begin
      if (rfr_valid && rfr_ready) gr[rfr_idx] = 1'b1;
      if (wb_req)  gw[evict_idx] = 1'b1;
      if (inv_req) gi[evict_idx] = 1'b1;
      if (j == LINES - 1) chk(scan_busy == 1'b1, "R2", "busy last line", int'(scan_busy), 1);
      if (j == LINES)     chk(scan_busy == 1'b0, "R2", "busy end", int'(scan_busy), 0);
      if (j == col) begin
        acc_valid = 1'b1; acc_idx = 3'(col); acc_write = 1'b0;
      end else begin
        acc_valid = 1'b0;
      end
      @(negedge clk);
    end
    acc_valid = 1'b0;
    chk(gr == er, "R3", "refresh set", int'(gr), int'(er));
    chk(gw == ew, "R5", "writeback set", int'(gw), int'(ew));
    chk(gi == ei, "R5", "invalidate set", int'(gi), int'(ei));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rfr_valid == 1'b0 && wb_req == 1'b0 && inv_req == 1'b0, "R1", "requests", int'(rfr_valid), 0);
    chk(cur_phase == 2'd0, "R1", "phase", int'(cur_phase), 0);
    chk(scan_busy == 1'b0 && overrun == 1'b0, "R1", "busy/overrun", int'(scan_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][28]) run_scan(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], -1);
      else            do_access(VEC[v][27:25], VEC[v][24]);
    end

    // R7: held request freezes the scan; phase is 1 here
    do_access(3'd5, 1'b0);
    do_access(3'd6, 1'b0);
    for (int k = 0; k < 3; k++) run_scan(8'h00, 8'h00, 8'h00, -1);
    rfr_ready = 1'b0;
    phase_tick = 1'b1;
    @(negedge clk);
    phase_tick = 1'b0;
    exp_phase = exp_phase + 2'd1;
    for (int k = 0; k < 20 && !rfr_valid; k++) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(rfr_valid && rfr_idx == 3'd5, "R7", "held request", int'(rfr_idx), 5);
      chk(scan_busy == 1'b1, "R7", "scan paused", int'(scan_busy), 1);
      @(negedge clk);
    end
    rfr_ready = 1'b1;
    @(negedge clk);
    chk(rfr_valid && rfr_idx == 3'd6, "R7", "next after accept", int'(rfr_idx), 6);
    repeat (LINES + 2) @(negedge clk);
    chk(scan_busy == 1'b0, "R7", "scan resumed to end", int'(scan_busy), 0);

    // R9: access collides with the scan on line 7
    do_access(3'd7, 1'b0);
    for (int k = 0; k < 3; k++) run_scan(8'h00, 8'h00, 8'h00, -1);
    run_scan(8'h00, 8'h00, 8'h60, 7);   // R9 line 7 silent; lines 5,6 retire
    for (int k = 0; k < 3; k++) run_scan(8'h00, 8'h00, 8'h00, -1);
    run_scan(8'h80, 8'h00, 8'h00, -1);  // R9 access was applied, line 7 still live

    // R8: tick during a running scan
    phase_tick = 1'b1;
    @(negedge clk);
    phase_tick = 1'b0;
    repeat (2) @(negedge clk);
    phase_tick = 1'b1;
    @(negedge clk);
    phase_tick = 1'b0;
    exp_phase = exp_phase + 2'd2;
    chk(overrun == 1'b1, "R8", "overrun pulse", int'(overrun), 1);
    chk(cur_phase == exp_phase, "R8", "phase after overrun", int'(cur_phase), int'(exp_phase));
    @(negedge clk);
    chk(overrun == 1'b0, "R8", "overrun single cycle", int'(overrun), 0);
    repeat (LINES - 2) @(negedge clk);
    chk(scan_busy == 1'b1, "R8", "restarted scan running", int'(scan_busy), 1);
    repeat (2) @(negedge clk);
    chk(scan_busy == 1'b0, "R8", "restarted scan done", int'(scan_busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule